// File: doc/BRIEF.md
# Dual-Channel LCD Segment/Common Driver Core

This block is the digital core of a 40-output dot-matrix LCD driver. The outputs are split into two 20-stage channels. Each channel has a serial shift register that can run in either direction and a parallel latch that feeds the outputs. The controller sends serial data together with a shift strobe and a latch strobe. Channel 2 can also act as a row (common) driver, and in that role it is clocked by the opposite strobe edges.

The controller strobes, the alternation input and the serial data are asynchronous to the fast system clock. The block passes each of them through a two-flop synchronizer and finds strobe edges by comparing successive samples. Each output pin is given as a 3-bit code naming one of six bias levels. The code is chosen from the latched bit, the synchronized alternation input and the mode input. Each bidirectional serial pin is modelled as a data input, a data output and an output enable.

Top module: `lcd_seg_com_core`

## Requirements
- R1: The two channels are independent. Channel 1 (index 0) drives outputs 1..20 and channel 2 (index 1) drives outputs 21..40. Output n uses `level_o[3n-1:3n-3]`.
- R2: With `dir_i[c]`=0, a shift event moves the synchronized left input into stage 1 and moves each stage k into stage k+1. `rgt_oe[c]`=1, `lft_oe[c]`=0, and `rgt_o[c]` shows stage 20.
- R3: With `dir_i[c]`=1, a shift event moves the synchronized right input into stage 20 and moves each stage k into stage k-1. `lft_oe[c]`=1, `rgt_oe[c]`=0, and `lft_o[c]` shows stage 1.
- R4: Channel 1 shifts on a falling shift strobe and latches on a falling latch strobe. When a shift event and a latch event fall in the same cycle, the latch takes the register contents from before that shift.
- R5: The latch, and therefore the outputs, stay unchanged between latch events, however many shifts occur.
- R6: With `com_mode_i`=0, channel 2 shifts and latches on exactly the same edges as channel 1.
- R7: With `com_mode_i`=1, channel 2 shifts on a rising latch strobe and latches on a rising shift strobe. Channel 1 is unaffected by the mode.
- R8: The channel 1 codes are: bit 1 gives 1 with alternation high and 2 with it low. Bit 0 gives 3 with alternation high and 4 with it low.
- R9: The channel 2 codes with `com_mode_i`=1 are: bit 1 gives 2 with alternation high and 1 with it low. Bit 0 gives 6 with alternation high and 5 with it low.
- R10: The channel 2 codes with `com_mode_i`=0 are: bit 1 gives 1 with alternation high and 2 with it low. Bit 0 gives 5 with alternation high and 6 with it low.
- R11: A low `rst_n` at a clock edge clears every shift stage and every latch bit. The strobe samplers load the current strobe levels, so releasing reset creates no edge.
- R12: A strobe change reaches the latch at the third rising clock edge after it is applied, and not at the second. A change of `alt_i` reaches the codes at the second rising edge, and not at the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lat_stb_i | input | 1 | Latch strobe from the controller (asynchronous) |
| sft_stb_i | input | 1 | Shift strobe from the controller (asynchronous) |
| alt_i | input | 1 | Drive alternation input (asynchronous) |
| com_mode_i | input | 1 | 1 = channel 2 acts as a common driver |
| dir_i | input | 2 | Shift direction per channel (bit c for channel c) |
| lft_i | input | 2 | Left serial pin input per channel |
| rgt_i | input | 2 | Right serial pin input per channel |
| lft_o | output | 2 | Left serial pin output per channel |
| rgt_o | output | 2 | Right serial pin output per channel |
| lft_oe | output | 2 | Left serial pin output enable per channel |
| rgt_oe | output | 2 | Right serial pin output enable per channel |
| level_o | output | 120 | Bias-level code per output, 3 bits each |

## Verification
A strobe edge changes the latch and the serial outputs three system clock edges after it is applied. An alternation change reaches the codes after two edges. Direction and mode act on the serial enables and on the codes at once. The bench applies every stimulus just after a falling clock edge and waits five falling edges before it compares the outputs with its own model of the shift registers and latches, so each result has settled. One directed case samples half a cycle after each of the second and third rising edges. This confirms that the latch result shows up exactly at the third edge and the alternation result exactly at the second.

// File: rtl/lcd_seg_com_core.sv
module lcd_seg_com_core #(
  parameter int CH_W  = 20,
  parameter int LVL_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lat_stb_i,
  input  logic                        sft_stb_i,
  input  logic                        alt_i,
  input  logic                        com_mode_i,
  input  logic [1:0]                  dir_i,
  input  logic [1:0]                  lft_i,
  input  logic [1:0]                  rgt_i,
  output logic [1:0]                  lft_o,
  output logic [1:0]                  rgt_o,
  output logic [1:0]                  lft_oe,
  output logic [1:0]                  rgt_oe,
  output logic [2*CH_W*LVL_W-1:0]     level_o
);

  localparam logic [LVL_W-1:0] L1 = LVL_W'(1);
  localparam logic [LVL_W-1:0] L2 = LVL_W'(2);
  localparam logic [LVL_W-1:0] L3 = LVL_W'(3);
  localparam logic [LVL_W-1:0] L4 = LVL_W'(4);
  localparam logic [LVL_W-1:0] L5 = LVL_W'(5);
  localparam logic [LVL_W-1:0] L6 = LVL_W'(6);

  logic [2:0] lat_q, sft_q;
  logic [1:0] alt_q;
  logic [1:0] lft_s1, lft_s2, rgt_s1, rgt_s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q  <= {3{lat_stb_i}};
      sft_q  <= {3{sft_stb_i}};
      alt_q  <= {2{alt_i}};
      lft_s1 <= '0;
      lft_s2 <= '0;
      rgt_s1 <= '0;
      rgt_s2 <= '0;
    end else begin
      lat_q  <= {lat_q[1:0], lat_stb_i};
      sft_q  <= {sft_q[1:0], sft_stb_i};
      alt_q  <= {alt_q[0], alt_i};
      lft_s1 <= lft_i;
      lft_s2 <= lft_s1;
      rgt_s1 <= rgt_i;
      rgt_s2 <= rgt_s1;
    end
  end

  logic lat_fall, lat_rise, sft_fall, sft_rise;
  logic [1:0] sh_ev, lt_ev;

  assign lat_fall = lat_q[2] & ~lat_q[1];
  assign lat_rise = ~lat_q[2] & lat_q[1];
  assign sft_fall = sft_q[2] & ~sft_q[1];
  assign sft_rise = ~sft_q[2] & sft_q[1];
  assign sh_ev    = {com_mode_i ? lat_rise : sft_fall, sft_fall};
  assign lt_ev    = {com_mode_i ? sft_rise : lat_fall, lat_fall};

  logic [CH_W-1:0] sr [2];
  logic [CH_W-1:0] lt [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        sr[c] <= '0;
        lt[c] <= '0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (lt_ev[c]) lt[c] <= sr[c];
        if (sh_ev[c])
          sr[c] <= dir_i[c] ? {rgt_s2[c], sr[c][CH_W-1:1]}
                            : {sr[c][CH_W-2:0], lft_s2[c]};
      end
    end
  end

  function automatic logic [LVL_W-1:0] pick(input logic upper, input logic com,
                                            input logic b, input logic m);
    if (upper && com) return b ? (m ? L2 : L1) : (m ? L6 : L5);
    if (b)            return m ? L1 : L2;
    if (upper)        return m ? L5 : L6;
    return m ? L3 : L4;
  endfunction

  for (genvar c = 0; c < 2; c++) begin : g_ch
    assign lft_o[c]  = sr[c][0];
    assign rgt_o[c]  = sr[c][CH_W-1];
    assign lft_oe[c] = dir_i[c];
    assign rgt_oe[c] = ~dir_i[c];

    for (genvar b = 0; b < CH_W; b++) begin : g_pin
      assign level_o[(c*CH_W+b)*LVL_W +: LVL_W] = pick(c == 1, com_mode_i, lt[c][b], alt_q[1]);
    end

    p_latch_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lt_ev[c] |=> lt[c] == $past(sr[c]));
    p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !lt_ev[c] |=> $stable(lt[c]));
    p_shift_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sh_ev[c] && !dir_i[c] |=> sr[c][CH_W-1:1] == $past(sr[c][CH_W-2:0]));
    p_shift_rev_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sh_ev[c] && dir_i[c] |=> sr[c][CH_W-2:0] == $past(sr[c][CH_W-1:1]));
    p_reg_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_ev[c] |=> $stable(sr[c]));
    p_reset_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (lt[c] == '0 && sr[c] == '0));
  end

endmodule

// File: tb/lcd_seg_com_core_tb.sv
module lcd_seg_com_core_tb;
  localparam int W  = 20;
  localparam int LW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, lat, sft, alt, com;
  logic [1:0] dir, lft, rgt;
  logic [1:0] lft_o, rgt_o, lft_oe, rgt_oe;
  logic [2*W*LW-1:0] level_o;

  lcd_seg_com_core #(.CH_W(W), .LVL_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .lat_stb_i(lat), .sft_stb_i(sft), .alt_i(alt),
    .com_mode_i(com), .dir_i(dir), .lft_i(lft), .rgt_i(rgt),
    .lft_o(lft_o), .rgt_o(rgt_o), .lft_oe(lft_oe), .rgt_oe(rgt_oe), .level_o(level_o));

  int n_chk = 0;
  int n_err = 0;
  logic [W-1:0] m_sr [2];
  logic [W-1:0] m_lt [2];
  logic m_alt;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_lvl(input int ch, input bit cm, input bit b, input bit m);
    if (ch == 0) return b ? (m ? 3'd1 : 3'd2) : (m ? 3'd3 : 3'd4);
    if (cm)      return b ? (m ? 3'd2 : 3'd1) : (m ? 3'd6 : 3'd5);
    return b ? (m ? 3'd1 : 3'd2) : (m ? 3'd5 : 3'd6);
  endfunction

  function automatic logic [W*LW-1:0] exp_slice(input int ch);
    logic [W*LW-1:0] v;
    for (int b = 0; b < W; b++) v[b*LW +: LW] = exp_lvl(ch, com, m_lt[ch][b], m_alt);
    return v;
  endfunction

  task automatic step();
    repeat (5) @(negedge clk);
  endtask

  task automatic mshift(input int c);
    if (!dir[c]) m_sr[c] = {m_sr[c][W-2:0], lft[c]};
    else         m_sr[c] = {rgt[c], m_sr[c][W-1:1]};
  endtask

  task automatic model_edge(input bit t_lat, input bit t_sft);
    bit lf, lr, sf, srs;
    lf  = t_lat && lat;
    lr  = t_lat && !lat;
    sf  = t_sft && sft;
    srs = t_sft && !sft;
    if (lf) m_lt[0] = m_sr[0];
    if (com ? srs : lf) m_lt[1] = m_sr[1];
    if (sf) mshift(0);
    if (com ? lr : sf) mshift(1);
  endtask

  task automatic strobe(input bit t_lat, input bit t_sft);
    model_edge(t_lat, t_sft);
    lat = lat ^ t_lat;
    sft = sft ^ t_sft;
    step();
  endtask

  task automatic check_all(input string note);
    for (int c = 0; c < 2; c++) begin
      string tag;
      tag = (c == 0) ? "R8" : (com ? "R9" : "R10");
      chk(level_o[c*W*LW +: W*LW] == exp_slice(c), {tag, " ", note},
          64'(level_o[c*W*LW +: W*LW]), 64'(exp_slice(c)));
      if (dir[c])
        chk({lft_oe[c], rgt_oe[c], lft_o[c]} == {2'b10, m_sr[c][0]}, {"R3 ", note},
            64'({lft_oe[c], rgt_oe[c], lft_o[c]}), 64'({2'b10, m_sr[c][0]}));
      else
        chk({lft_oe[c], rgt_oe[c], rgt_o[c]} == {2'b01, m_sr[c][W-1]}, {"R2 ", note},
            64'({lft_oe[c], rgt_oe[c], rgt_o[c]}), 64'({2'b01, m_sr[c][W-1]}));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [2*W*LW-1:0] snap;
    void'($urandom(32'd7065));
    rst_n = 0; lat = 1; sft = 1; alt = 0; com = 0; dir = 2'b00; lft = 0; rgt = 0;
    m_alt = 0;
    for (int c = 0; c < 2; c++) begin m_sr[c] = '0; m_lt[c] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    step();
    // R11: cleared state, alternation low -> channel 1 code 4, channel 2 code 6
    for (int c = 0; c < 2; c++)
      chk(level_o[c*W*LW +: W*LW] == exp_slice(c), "R11 reset codes",
          64'(level_o[c*W*LW +: W*LW]), 64'(exp_slice(c)));
    check_all("after reset R11");

    // R12: latch strobe timing
    lft = 2'b01; step();
    strobe(0, 1);
    strobe(0, 1);
    model_edge(1, 0);
    lat = 0;
    repeat (2) @(negedge clk);
    chk(level_o[2:0] == 3'd4, "R12 latch not yet at second edge", 64'(level_o[2:0]), 64'd4);
    @(negedge clk);
    chk(level_o[2:0] == 3'd2, "R12 latch at third edge", 64'(level_o[2:0]), 64'd2);
    step();
    // R12: alternation timing
    alt = 1;
    @(negedge clk);
    chk(level_o[2:0] == 3'd2, "R12 alternation not yet at first edge", 64'(level_o[2:0]), 64'd2);
    @(negedge clk);
    chk(level_o[2:0] == 3'd1, "R12 alternation at second edge", 64'(level_o[2:0]), 64'd1);
    m_alt = 1;
    step();
    check_all("R12 end");

    // R1 / R6: distinct patterns per channel, segment mode
    lft = 2'b01; step();
    if (!sft) strobe(0, 1);
    for (int i = 0; i < W; i++) strobe(0, 1);
    if (!lat) strobe(1, 0);
    strobe(1, 0);
    check_all("R1 R6 independent channels");

    // R4: simultaneous shift and latch events
    lft = 2'b10; step();
    strobe(1, 1);
    strobe(1, 1);
    strobe(1, 1);
    check_all("R4 same-cycle shift and latch");

    // R5: shifting without latching leaves outputs
    snap = level_o;
    for (int i = 0; i < 6; i++) strobe(0, 1);
    chk(level_o == snap, "R5 hold across shifts", 64'(level_o[63:0]), 64'(snap[63:0]));
    chk(level_o[2*W*LW-1:64] == snap[2*W*LW-1:64], "R5 hold upper",
        64'(level_o[2*W*LW-1:64]), 64'(snap[2*W*LW-1:64]));

    // R3: reverse direction on both channels
    dir = 2'b11; rgt = 2'b11; step();
    for (int i = 0; i < 5; i++) strobe(0, 1);
    strobe(1, 0);
    check_all("R3 reverse load");

    // R7 / R9: common role on channel 2
    com = 1; dir = 2'b00; lft = 2'b10; step();
    check_all("R7 R9 mode switch");
    for (int i = 0; i < 8; i++) strobe(1, 0);
    check_all("R7 latch strobe shifts channel 2");
    strobe(0, 1);
    strobe(0, 1);
    check_all("R7 shift strobe latches channel 2");
    alt = 0; m_alt = 0; step();
    check_all("R9 alternation low");

    // constrained random mix
    for (int it = 0; it < 500; it++) begin
      int r;
      r = int'($urandom % 10);
      case (r)
        0, 1: begin lft = 2'($urandom); rgt = 2'($urandom); step(); end
        2, 3: strobe(0, 1);
        4, 5: strobe(1, 0);
        6:    strobe(1, 1);
        7:    begin alt = ~alt; m_alt = alt; step(); end
        default: begin com = 1'($urandom); dir = 2'($urandom); step(); end
      endcase
      check_all("random R10 mix");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule